// File: doc/BRIEF.md
# Register-Immediate Integer Execute Unit

This block decodes and executes the six register-immediate integer operations of a 32-bit instruction word: add, signed set-less-than, unsigned set-less-than, and the three bitwise logic operations. The caller presents an instruction together with a valid strobe. The unit reads the source register from its internal 32 by 32-bit register file without waiting for a clock. It forms the sign-extended 12-bit immediate and computes the result. On the next rising clock edge it writes that result into the destination register.

An instruction the unit does not handle produces a one-cycle illegal flag and leaves every register unchanged. This covers any opcode other than the register-immediate one, and the two shift encodings of the function field. A debug read port returns the contents of any register combinationally, so a testbench or a neighbouring block can inspect the architectural state.

Top module: `imm_exec_unit`

## Requirements
- R1: An instruction is accepted only when its bits [6:0] equal 7'b0010011; any other opcode presented with the valid strobe writes no register and raises `illegal` for the cycle after the clock edge that took it.
- R2: The fields are taken from fixed positions: destination at [11:7], function code at [14:12], source at [19:15], and immediate at [31:20]. The immediate is sign-extended from bit 31, so 12'hF8C becomes 32'hFFFFFF8C. Word 32'h00560693 adds 5 to register 12 and writes the sum to register 13.
- R3: Function code 000 writes the source plus the extended immediate modulo 2^32; a carry out of bit 31 is dropped and raises no flag.
- R4: Function code 010 writes 1 when the source is less than the extended immediate as two's-complement numbers, and 0 otherwise.
- R5: Function code 011 sign-extends the immediate, then compares both operands as unsigned and writes 1 or 0. With immediate 1 it writes 1 only for a zero source; with immediate 12'hFFF it writes 1 for every source except 32'hFFFFFFFF.
- R6: Function codes 100, 110 and 111 write the bitwise XOR, OR and AND of the source and the extended immediate; XOR with 12'hFFF yields the complement of the source.
- R7: Register 0 always reads as zero on both the debug port and the source path, and writes addressed to it are discarded.
- R8: Function codes 001 and 101 under the accepted opcode write no register and raise `illegal` for exactly one cycle.
- R9: While `rst_n` is low at a clock edge every register clears to zero and `illegal` clears to 0.
- R10: With `instr_valid` low, no register changes and `illegal` stays 0 whatever the instruction bits are.
- R11: Source and destination may name the same register; the source value is the one held before the edge, and the result replaces it at the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; results are written on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction strobe; the word is executed at the next rising edge |
| instr | input | 32 | Instruction word |
| dbg_addr | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Combinational contents of the register chosen by `dbg_addr` |
| illegal | output | 1 | One-cycle flag for an unhandled instruction taken with the strobe |

## Verification
The assertions assume that `instr_valid` and `instr` are stable and free of unknown bits around each rising edge, and that `dbg_addr` always names one of the 32 registers. The bench drives every input on the falling edge and holds it for a full cycle, so this holds. It draws only 5-bit indices and fully defined random words. When the strobe is low it still keeps the instruction bits at defined values, so that the idle case is tested against a real encoding.

// File: rtl/imm_exec_pkg.sv
// Shared constants and types for the register-immediate execute unit.
// Assumes a 32-bit instruction word with the fixed I-type field layout.
package imm_exec_pkg;

    localparam int INSTR_W   = 32;
    localparam int IMM_W     = 12;
    localparam int OPC_W     = 7;
    localparam int F3_W      = 3;

    localparam logic [OPC_W-1:0] OPC_REG_IMM = 7'b0010011;

    localparam logic [F3_W-1:0] F3_ADD  = 3'b000;
    localparam logic [F3_W-1:0] F3_SLT  = 3'b010;
    localparam logic [F3_W-1:0] F3_SLTU = 3'b011;
    localparam logic [F3_W-1:0] F3_XOR  = 3'b100;
    localparam logic [F3_W-1:0] F3_OR   = 3'b110;
    localparam logic [F3_W-1:0] F3_AND  = 3'b111;

    // Operation selected for the arithmetic/logic stage.
    typedef enum logic [2:0] {
        OP_ADD,
        OP_SLT,
        OP_SLTU,
        OP_XOR,
        OP_OR,
        OP_AND
    } alu_op_e;

endpackage

// File: rtl/imm_decode.sv
// Field extraction and operation select for one instruction word.
// Purely combinational; assumes the instruction is stable for the cycle.
module imm_decode
    import imm_exec_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int REG_AW = 5
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               legal,
    output alu_op_e            op,
    output logic [REG_AW-1:0]  rd,
    output logic [REG_AW-1:0]  rs1,
    output logic [XLEN-1:0]    imm
);

    localparam int EXT_W = XLEN - IMM_W;

    logic [F3_W-1:0] f3;

    // Fixed field positions of the immediate format.
    assign rd  = instr[7 +: REG_AW];
    assign rs1 = instr[15 +: REG_AW];
    assign f3  = instr[14:12];

    // Sign extension copies instruction bit 31 into all upper bits.
    assign imm = {{EXT_W{instr[31]}}, instr[31:20]};

    // Maps the function code to an operation and flags unhandled words.
    always_comb begin
        legal = (instr[OPC_W-1:0] == OPC_REG_IMM);
        op    = OP_ADD;
        unique case (f3)
            F3_ADD:  op = OP_ADD;
            F3_SLT:  op = OP_SLT;
            F3_SLTU: op = OP_SLTU;
            F3_XOR:  op = OP_XOR;
            F3_OR:   op = OP_OR;
            F3_AND:  op = OP_AND;
            default: legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/imm_alu.sv
// Result computation for the six register-immediate operations.
// Combinational; assumes both operands are already full width.
module imm_alu
    import imm_exec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    logic lt_signed;
    logic lt_unsigned;

    // Both comparisons are formed once and selected below.
    assign lt_signed   = ($signed(a) < $signed(b));
    assign lt_unsigned = (a < b);

    // Selects the result; the add wraps with the carry discarded.
    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SLT:  y = {{(XLEN-1){1'b0}}, lt_signed};
            OP_SLTU: y = {{(XLEN-1){1'b0}}, lt_unsigned};
            OP_XOR:  y = a ^ b;
            OP_OR:   y = a | b;
            OP_AND:  y = a & b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/imm_regfile.sv
// Integer register file: combinational source and debug reads, one write per edge.
// Entry 0 has no storage and always reads zero; synchronous active-low reset.
module imm_regfile #(
    parameter int XLEN   = 32,
    parameter int NREGS  = 32,
    parameter int REG_AW = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [XLEN-1:0]   wdata,
    input  logic [REG_AW-1:0] raddr,
    output logic [XLEN-1:0]   rdata,
    input  logic [REG_AW-1:0] dbg_addr,
    output logic [XLEN-1:0]   dbg_data
);

    logic [XLEN-1:0] rows [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_row
        if (g == 0) begin : g_zero
            // Register 0 is a constant zero; writes to it fall away.
            assign rows[g] = '0;
        end else begin : g_store
            logic [XLEN-1:0] q;
            // Clears on reset, otherwise captures the write aimed at this entry.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (we && (waddr == REG_AW'(g)))
                    q <= wdata;
            end
            assign rows[g] = q;
        end
    end

    // Both read ports see the value held before the coming edge.
    assign rdata    = rows[raddr];
    assign dbg_data = rows[dbg_addr];

endmodule

// File: rtl/imm_exec_unit.sv
// Top of the register-immediate execute unit: decode, operate, write back.
// Assumes instr and instr_valid are held stable across the sampling edge.
module imm_exec_unit
    import imm_exec_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int NREGS  = 32,
    parameter int REG_AW = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [REG_AW-1:0] dbg_addr,
    output logic [XLEN-1:0]   dbg_data,
    output logic              illegal
);

    logic              dec_legal;
    alu_op_e           dec_op;
    logic [REG_AW-1:0] dec_rd;
    logic [REG_AW-1:0] dec_rs1;
    logic [XLEN-1:0]   dec_imm;
    logic [XLEN-1:0]   rs1_val;
    logic [XLEN-1:0]   alu_y;
    logic              wr_en;
    logic              illegal_q;

    imm_decode #(.XLEN(XLEN), .REG_AW(REG_AW)) u_dec (
        .instr (instr),
        .legal (dec_legal),
        .op    (dec_op),
        .rd    (dec_rd),
        .rs1   (dec_rs1),
        .imm   (dec_imm)
    );

    imm_alu #(.XLEN(XLEN)) u_alu (
        .op (dec_op),
        .a  (rs1_val),
        .b  (dec_imm),
        .y  (alu_y)
    );

    // A write happens only for a strobed, handled instruction.
    assign wr_en = instr_valid && dec_legal;

    imm_regfile #(.XLEN(XLEN), .NREGS(NREGS), .REG_AW(REG_AW)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_en),
        .waddr    (dec_rd),
        .wdata    (alu_y),
        .raddr    (dec_rs1),
        .rdata    (rs1_val),
        .dbg_addr (dbg_addr),
        .dbg_data (dbg_data)
    );

    // Registers the one-cycle flag for a strobed but unhandled word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            illegal_q <= 1'b0;
        else
            illegal_q <= instr_valid && !dec_legal;
    end

    assign illegal = illegal_q;

endmodule

// File: rtl/imm_exec_check.sv
// Assertion checker for the execute unit, attached to every instance by bind.
// Assumes a clean synchronous reset before the first checked cycle.
module imm_exec_check
    import imm_exec_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [INSTR_W-1:0] instr,
    input logic [REG_AW-1:0] dbg_addr,
    input logic [XLEN-1:0]   dbg_data,
    input logic              illegal,
    input logic              wr_en,
    input logic [XLEN-1:0]   wr_data
);

    assert_bad_opcode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[6:0] != OPC_REG_IMM) |=> illegal);

    assert_shift_codes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[6:0] == OPC_REG_IMM &&
         (instr[14:12] == 3'b001 || instr[14:12] == 3'b101)) |=> illegal);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> !illegal);

    assert_zero_reg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_addr == '0) |-> (dbg_data == '0));

    assert_compare_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (instr[14:12] == F3_SLT || instr[14:12] == F3_SLTU))
        |-> (wr_data[XLEN-1:1] == '0));

    assert_write_no_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !illegal);

endmodule

bind imm_exec_unit imm_exec_check #(.XLEN(XLEN), .REG_AW(REG_AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .dbg_addr    (dbg_addr),
    .dbg_data    (dbg_data),
    .illegal     (illegal),
    .wr_en       (wr_en),
    .wr_data     (alu_y)
);

// File: tb/imm_exec_unit_test.sv
`timescale 1ns/1ps
module imm_exec_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = 32'h0000_0013;
    logic [4:0]  dbg_addr = '0;
    logic [31:0] dbg_data;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] model [32];

    always #2.5 clk = ~clk;

    imm_exec_unit uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .dbg_addr(dbg_addr), .dbg_data(dbg_data), .illegal(illegal)
    );

    function automatic logic [31:0] sx(input logic [11:0] i);
        return {{20{i[11]}}, i};
    endfunction

    function automatic logic [31:0] mk(input logic [2:0] f3, input logic [4:0] rd,
                                       input logic [4:0] rs, input logic [11:0] imm);
        return {imm, rs, f3, rd, 7'b0010011};
    endfunction

    function automatic bit ok_word(input logic [31:0] w);
        return (w[6:0] == 7'b0010011) && (w[14:12] != 3'b001) && (w[14:12] != 3'b101);
    endfunction

    function automatic logic [31:0] expect_res(input logic [31:0] w, input logic [31:0] a);
        logic [31:0] b;
        b = sx(w[31:20]);
        case (w[14:12])
            3'b000:  return a + b;
            3'b010:  return {31'd0, ($signed(a) < $signed(b))};
            3'b011:  return {31'd0, (a < b)};
            3'b100:  return a ^ b;
            3'b110:  return a | b;
            default: return a & b;
        endcase
    endfunction

    function automatic string req_of(input logic [31:0] w);
        if (w[6:0] != 7'b0010011) return "R1";
        case (w[14:12])
            3'b000:  return "R3";
            3'b010:  return "R4";
            3'b011:  return "R5";
            3'b001, 3'b101: return "R8";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Executes one strobed word and checks the flag and the destination.
    task automatic run(input logic [31:0] w, input string req);
        logic [31:0] res;
        logic [4:0]  rd;
        bit          good;
        good = ok_word(w);
        rd   = w[11:7];
        res  = expect_res(w, model[w[19:15]]);
        @(negedge clk);
        instr = w;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        if (good && rd != 0) model[rd] = res;
        dbg_addr = rd;
        #0.5;
        chk(req, {31'd0, illegal}, {31'd0, !good});
        chk(req, dbg_data, model[rd]);
    endtask

    // Presents a word with the strobe low and checks nothing moved (R10).
    task automatic idle(input logic [31:0] w);
        @(negedge clk);
        instr = w;
        instr_valid = 1'b0;
        @(negedge clk);
        dbg_addr = w[11:7];
        #0.5;
        chk("R10", {31'd0, illegal}, 32'd0);
        chk("R10", dbg_data, model[w[11:7]]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        instr_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 32; i++) model[i] = '0;
        chk("R9", {31'd0, illegal}, 32'd0);
        for (int i = 0; i < 32; i++) begin
            dbg_addr = 5'(i);
            #0.1;
            chk("R9", dbg_data, 32'd0);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        logic [11:0] imm;
        void'($urandom(32'd20240611));
        do_reset();

        // R2: field positions and sign extension
        run(mk(3'b000, 5'd3, 5'd0, 12'hF8C), "R2");
        run(mk(3'b000, 5'd12, 5'd0, 12'd100), "R2");
        run(32'h0056_0693, "R2");
        // R3: wrap-around without flag
        run(mk(3'b000, 5'd1, 5'd0, 12'hFFF), "R3");
        run(mk(3'b000, 5'd2, 5'd1, 12'd1), "R3");
        // R4 / R5: signed versus unsigned with a negative source
        run(mk(3'b010, 5'd4, 5'd1, 12'd1), "R4");
        run(mk(3'b010, 5'd4, 5'd0, 12'hFFF), "R4");
        run(mk(3'b011, 5'd5, 5'd1, 12'd1), "R5");
        run(mk(3'b011, 5'd5, 5'd2, 12'd1), "R5");
        run(mk(3'b011, 5'd6, 5'd3, 12'hFFF), "R5");
        run(mk(3'b011, 5'd6, 5'd1, 12'hFFF), "R5");
        // R6: logic operations and complement
        run(mk(3'b100, 5'd7, 5'd12, 12'hFFF), "R6");
        run(mk(3'b110, 5'd8, 5'd12, 12'h005), "R6");
        run(mk(3'b111, 5'd9, 5'd3, 12'h0F0), "R6");
        // R7: register 0 stays zero
        run(mk(3'b000, 5'd0, 5'd1, 12'h123), "R7");
        run(mk(3'b000, 5'd0, 5'd0, 12'h000), "R7");
        run(mk(3'b000, 5'd10, 5'd0, 12'h000), "R7");
        // R11: same register as source and destination
        run(mk(3'b000, 5'd12, 5'd12, 12'd3), "R11");
        run(mk(3'b100, 5'd12, 5'd12, 12'hFFF), "R11");
        // R8 and R1: unhandled words change nothing
        run(mk(3'b001, 5'd12, 5'd1, 12'd1), "R8");
        run(mk(3'b101, 5'd3, 5'd1, 12'd1), "R8");
        run({12'd7, 5'd0, 3'b000, 5'd13, 7'b0110011}, "R1");
        run({12'd7, 5'd0, 3'b000, 5'd13, 7'b0000011}, "R1");
        // R10: strobe low
        idle(mk(3'b000, 5'd13, 5'd1, 12'd9));

        for (int n = 0; n < 600; n++) begin
            case ($urandom_range(0, 5))
                0: imm = 12'hFFF;
                1: imm = 12'h800;
                2: imm = 12'h7FF;
                3: imm = 12'h001;
                default: imm = 12'($urandom);
            endcase
            w = mk(3'($urandom), 5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)), imm);
            if ($urandom_range(0, 9) == 0) w[6:0] = 7'($urandom);
            if ($urandom_range(0, 12) == 0) idle(w);
            else run(w, req_of(w));
        end

        do_reset();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule